// File: doc/BRIEF.md
# FM/MFM Flux Write Encoder

This block turns a stream of bytes into flux-transition pulses for the write-data line of a floppy drive. The host offers bytes over a valid/ready handshake into a one-entry holding register. The encoder shifts each byte out starting at the most significant bit. Every data bit occupies two bit cells: a clock cell first, then a data cell. The encoder moves forward by one cell on each pulse of a cell-tick input. That tick comes from a write clock running at twice the data bit rate, for example 500 kHz for FM at 250 kbit/s and 1 MHz for MFM at 500 kbit/s.

A mode input chooses the cell rules. In FM every clock cell carries a transition. In MFM the clock cell depends on the data bit before it, and that history carries from one byte into the next. Mode is taken only when a new byte enters the shifter, so a single byte is never encoded with two rule sets. If no byte is waiting when the current one runs out after the stream has begun, a sticky underrun flag rises and the encoder writes empty cells.

Top module: `flux_write_encoder`

## Requirements
- R1: After reset, `in_ready` is 1, and `wr_pulse` and `underrun` are 0.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle onward, for as long as that byte waits in the one-entry holding register. The byte moves into the shifter only on a cell tick at a byte boundary.
- R3: Each byte produces 16 cells, one per cell tick, in order from bit 7 down to bit 0. For each bit the clock cell comes before the data cell. A cell with a transition makes `wr_pulse` 1 for exactly the one cycle after its tick. `wr_pulse` is never 1 at any other time.
- R4: With `mfm_sel`=0 (FM), every clock cell has a transition. The data cell has one exactly when the bit is 1, so a 1 encodes as 1/1 and a 0 as 1/0.
- R5: With `mfm_sel`=1 (MFM), a 1 bit encodes as 0/1. A 0 bit after a 1 encodes as 0/0. A 0 bit after a 0 encodes as 1/0.
- R6: In MFM the previous-bit history runs across byte boundaries. The first clock cell of a byte depends on bit 0 of the byte before it.
- R7: `mfm_sel` is sampled only at the tick that loads a byte into the shifter. Changing it in the middle of a byte does not affect that byte.
- R8: Reset, and any change of mode at a byte load, both clear the previous-bit history to 0.
- R9: At a byte-boundary tick with no byte waiting, the cell is empty. If at least one byte has been loaded since reset, `underrun` becomes 1 in the following cycle and stays 1 until reset. Before the first byte it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_tick | input | 1 | One-cycle strobe per bit cell (write clock) |
| mfm_sel | input | 1 | Encoding select: 0 = FM, 1 = MFM |
| in_data | input | 8 | Byte offered by the host |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Holding register empty, byte will be taken |
| wr_pulse | output | 1 | One-cycle transition pulse for the write-data line |
| underrun | output | 1 | Sticky flag: byte not supplied in time |

## Verification
The output timing is fixed relative to each stimulus. A cell's pulse appears in the cycle right after its tick edge, and `underrun` rises in the cycle after the starved boundary tick. `in_ready` falls in the cycle after the accepting edge and rises in the cycle after the loading tick. The bench model updates its expected values at each rising edge from the inputs seen at that edge. It then compares them with the outputs at the following falling edge, so every result is checked in the exact cycle it is due. The stimulus drives inputs on falling edges. It changes `mfm_sel` in the middle of a byte, and it runs out of bytes at the end to force an underrun.

// File: rtl/flux_enc_pkg.sv
package flux_enc_pkg;

    typedef enum logic {
        ENC_FM  = 1'b0,
        ENC_MFM = 1'b1
    } enc_mode_e;

    typedef enum logic {
        CELL_CLK = 1'b0,
        CELL_DAT = 1'b1
    } cell_kind_e;

endpackage

// File: rtl/flux_hold_buf.sv
// One-entry holding register between the host handshake and the shifter.
module flux_hold_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         take,
    output logic         in_ready,
    output logic         full,
    output logic [W-1:0] data
);

    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_t;

    hold_t hb_d, hb_q;

    always_comb begin
        hb_d = hb_q;
        if (take) begin
            hb_d.full = 1'b0;
        end
        if (in_valid && !hb_q.full) begin
            hb_d.full = 1'b1;
            hb_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q <= '0;
        end else begin
            hb_q <= hb_d;
        end
    end

    assign in_ready = !hb_q.full;
    assign full     = hb_q.full;
    assign data     = hb_q.data;

endmodule

// File: rtl/flux_cell_rule.sv
// Decides whether one bit cell holds a transition.
module flux_cell_rule
    import flux_enc_pkg::*;
(
    input  enc_mode_e  mode,
    input  cell_kind_e kind,
    input  logic       bit_val,
    input  logic       prev_bit,
    output logic       has_flux
);

    always_comb begin
        if (kind == CELL_DAT) begin
            has_flux = bit_val;
        end else if (mode == ENC_FM) begin
            has_flux = 1'b1;
        end else begin
            has_flux = !prev_bit && !bit_val;
        end
    end

endmodule

// File: rtl/flux_cell_seq.sv
// Cell sequencer: loads bytes at boundaries, walks 2*W cells per byte.
module flux_cell_seq
    import flux_enc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cell_tick,
    input  logic         mode_sel,
    input  logic         buf_full,
    input  logic [W-1:0] buf_data,
    output logic         take,
    output logic         wr_pulse,
    output logic         underrun,
    output logic         active,
    output logic         data_cell,
    output logic         mode_mfm
);

    localparam int CELLS = 2 * W;
    localparam int CNT_W = $clog2(CELLS);
    localparam int IDX_W = CNT_W - 1;
    localparam logic [CNT_W-1:0] LAST_CELL = CNT_W'(CELLS - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     shreg;
        enc_mode_e        mode;
        logic             prev;
        logic             started;
        logic             underrun;
        logic             pulse;
    } seq_t;

    seq_t s_d, s_q;

    logic             load;
    logic [W-1:0]     cur_word;
    enc_mode_e        cur_mode;
    logic             cur_prev;
    logic [CNT_W-1:0] cur_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             cur_bit;
    cell_kind_e       cur_kind;
    logic             cell_val;

    always_comb begin
        load     = cell_tick && !s_q.active && buf_full;
        cur_word = load ? buf_data : s_q.shreg;
        cur_mode = load ? enc_mode_e'(mode_sel) : s_q.mode;
        cur_prev = (load && (cur_mode != s_q.mode)) ? 1'b0 : s_q.prev;
        cur_cnt  = load ? '0 : s_q.cnt;
        bit_idx  = IDX_W'(W - 1) - cur_cnt[CNT_W-1:1];
        cur_bit  = cur_word[bit_idx];
        cur_kind = cur_cnt[0] ? CELL_DAT : CELL_CLK;
    end

    flux_cell_rule u_rule (
        .mode     (cur_mode),
        .kind     (cur_kind),
        .bit_val  (cur_bit),
        .prev_bit (cur_prev),
        .has_flux (cell_val)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        take      = 1'b0;
        if (load) begin
            take        = 1'b1;
            s_d.shreg   = buf_data;
            s_d.mode    = cur_mode;
            s_d.prev    = cur_prev;
            s_d.started = 1'b1;
            s_d.active  = 1'b1;
        end
        if (cell_tick) begin
            if (s_q.active || load) begin
                s_d.pulse = cell_val;
                s_d.cnt   = cur_cnt + 1'b1;
                if (cur_kind == CELL_DAT) begin
                    s_d.prev = cur_bit;
                end
                if (cur_cnt == LAST_CELL) begin
                    s_d.active = 1'b0;
                end
            end else if (s_q.started) begin
                s_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_pulse  = s_q.pulse;
    assign underrun  = s_q.underrun;
    assign active    = s_q.active;
    assign data_cell = s_q.cnt[0];
    assign mode_mfm  = (s_q.mode == ENC_MFM);

endmodule

// File: rtl/flux_write_encoder.sv
module flux_write_encoder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cell_tick,
    input  logic         mfm_sel,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic         wr_pulse,
    output logic         underrun
);

    logic         buf_full;
    logic [W-1:0] buf_data;
    logic         take;
    logic         seq_active;
    logic         seq_data_cell;
    logic         seq_mfm;

    flux_hold_buf #(.W(W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .take     (take),
        .in_ready (in_ready),
        .full     (buf_full),
        .data     (buf_data)
    );

    flux_cell_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_tick (cell_tick),
        .mode_sel  (mfm_sel),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .take      (take),
        .wr_pulse  (wr_pulse),
        .underrun  (underrun),
        .active    (seq_active),
        .data_cell (seq_data_cell),
        .mode_mfm  (seq_mfm)
    );

endmodule

// File: rtl/flux_write_encoder_chk.sv
module flux_write_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cell_tick,
    input logic in_valid,
    input logic in_ready,
    input logic wr_pulse,
    input logic underrun,
    input logic seq_active,
    input logic seq_data_cell,
    input logic seq_mfm
);

    p_pulse_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(cell_tick));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !cell_tick) |=> !wr_pulse);

    p_accept_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_hold_until_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !cell_tick) |=> !in_ready);

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    p_underrun_empty_cell_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !wr_pulse);

    p_fm_clock_cell_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_tick && seq_active && !seq_data_cell && !seq_mfm) |=> wr_pulse);

endmodule

bind flux_write_encoder flux_write_encoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cell_tick     (cell_tick),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .wr_pulse      (wr_pulse),
    .underrun      (underrun),
    .seq_active    (seq_active),
    .seq_data_cell (seq_data_cell),
    .seq_mfm       (seq_mfm)
);

// File: tb/flux_write_encoder_test.sv
module flux_write_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cell_tick = 1'b0;
    logic       mfm_sel = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       wr_pulse;
    logic       underrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit tick_en = 1'b0;

    always #5 clk = ~clk;

    flux_write_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_tick (cell_tick),
        .mfm_sel   (mfm_sel),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .wr_pulse  (wr_pulse),
        .underrun  (underrun)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] pend[$];
    bit         cellq[$];
    string      tagq[$];
    bit         m_mode, m_prev, m_started, m_fresh;
    bit         exp_pulse, exp_under;
    string      exp_tag;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete(); cellq.delete(); tagq.delete();
            m_mode = 1'b0; m_prev = 1'b0; m_started = 1'b0; m_fresh = 1'b1;
            exp_pulse = 1'b0; exp_under = 1'b0; exp_tag = "R3";
        end else begin
            bit rdy_pre;
            rdy_pre   = (pend.size() == 0);
            exp_pulse = 1'b0;
            if (cell_tick) begin
                if (cellq.size() == 0) begin
                    if (pend.size() > 0) begin
                        logic [7:0] b;
                        bit m;
                        b = pend.pop_front();
                        m = mfm_sel;
                        if (m != m_mode) begin
                            m_prev  = 1'b0;
                            m_fresh = 1'b1;
                        end
                        m_mode = m;
                        for (int i = 7; i >= 0; i--) begin
                            bit d, c;
                            string t;
                            d = b[i];
                            if (m) begin
                                c = !m_prev && !d;
                                if (i == 7) t = m_fresh ? "R8" : "R6";
                                else        t = "R5";
                            end else begin
                                c = 1'b1;
                                t = "R4";
                            end
                            cellq.push_back(c); tagq.push_back({"R3/", t});
                            cellq.push_back(d); tagq.push_back({"R3/", t});
                            m_prev = d;
                        end
                        m_fresh   = 1'b0;
                        m_started = 1'b1;
                    end else if (m_started) begin
                        exp_under = 1'b1;
                    end
                end
                if (cellq.size() > 0) begin
                    exp_pulse = cellq.pop_front();
                    exp_tag   = tagq.pop_front();
                    if (mfm_sel != m_mode) exp_tag = {exp_tag, "/R7"};
                end else begin
                    exp_tag = "R9";
                end
            end else begin
                exp_tag = "R3";
            end
            if (in_valid && rdy_pre) pend.push_back(in_data);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({"wr_pulse ", exp_tag}, wr_pulse, exp_pulse);
            check("underrun R9", underrun, exp_under);
            check("in_ready R2", in_ready, pend.size() == 0);
        end
    end

    // ---------------- cell tick generator ----------------
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            cell_tick = tick_en && (n % 4 == 0);
            n++;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 ready low after accept", in_ready, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in_ready", in_ready, 1'b1);
        check("R1 wr_pulse", wr_pulse, 1'b0);
        check("R1 underrun", underrun, 1'b0);
        rst_n = 1'b1;
        tick_en = 1'b1;

        // idle ticks: no stream started, no underrun (R9)
        repeat (40) @(negedge clk);
        check("R9 no underrun before first byte", underrun, 1'b0);

        // FM stream
        mfm_sel = 1'b0;
        send(8'hA5);
        send(8'h00);
        send(8'hFF);
        send(8'h00);
        // FF still encoding FM; the waiting 00 loads as MFM (R7, R8)
        mfm_sel = 1'b1;
        send(8'h80);
        send(8'h01);
        send(8'h00);
        send(8'h4E);
        send(8'h11);
        send(8'hFF);
        mfm_sel = 1'b0;
        send(8'h3C);
        send(8'hC3);
        // starve the encoder
        repeat (200) @(negedge clk);
        check("R9 underrun after starvation", underrun, 1'b1);
        check("R9 empty cells after underrun", wr_pulse, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule